// File: doc/BRIEF.md
# Program-Stepped Mesh Tile Switch

This block is the crossbar switch of one tile in a two-dimensional mesh whose routes are fixed before the program runs. It has five 32-bit links: four to the neighbouring tiles (north, east, south, west) and one to the local processor. Each link has an input side and an output side. No routing choice is taken from the data. A small instruction store, filled through a plain write port, holds a schedule. Each instruction says, for every output, which input feeds it in that step. The switch retires the instructions one after the other. The order of words on every output is therefore known when the schedule is written.

Every incoming word first lands in a small registered input buffer. An instruction retires only in a cycle where every route it names can complete: each named source buffer holds a word, and each named output queue has room. In that case all the routes move together. Otherwise nothing moves and the program counter holds. Output queues send to the neighbour only while they hold link credits. The neighbour returns one credit per word it frees. Toward the upstream side, the switch pulses one credit for each word it removes from an input buffer. The program counter returns to zero after a programmable last address, so a schedule repeats. A run input gates the whole stepping.

Top module: `static_route_switch`

## Requirements
- R1: While rst_n is low and after it is released, every out_valid and in_credit bit is 0. The instruction store reads as all-idle, the program counter is 0, and every output holds its full link-credit allowance.
- R2: An instruction is 15 bits. The source select for output port o (0=north, 1=east, 2=south, 3=west, 4=local) sits in bits [3o+2:3o]. Codes 0..4 pick the input with that port number, and codes 5, 6 and 7 mean the output takes no word in that step.
- R3: A word presented with in_valid before clock edge k, and routed by a retiring instruction, appears on the chosen out_data with out_valid high after edge k+1 (two edges from link to link), with its value unchanged.
- R4: One instruction may name the same input for several outputs. The word is copied to all of them in the same cycle, and the input is consumed once (one in_credit pulse).
- R5: An instruction retires only when all of its named sources hold a word and all of its named output queues have room. Otherwise no word moves on any of its routes and the program counter holds.
- R6: Each retired instruction advances the program counter by one. After the instruction at address cfg_last it returns to address 0.
- R7: While run is low, no instruction retires, and no word is taken from any input buffer.
- R8: out_valid is raised only while the output has at least one link credit. Each word sent uses one credit, and each out_credit pulse returns one. When the output queue is full, a route into it cannot fire.
- R9: in_credit on a port pulses high for exactly one cycle for each word taken from that port's input buffer.
- R10: Words leave each output in the order given by the instruction sequence, whatever order they arrived in on the inputs.
- R11: An instruction whose five selects are all idle retires in a single cycle with no data movement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Lets the schedule step while high |
| cfg_last | input | 4 | Address of the last instruction before wrap |
| imem_we | input | 1 | Instruction store write enable |
| imem_addr | input | 4 | Instruction store write address |
| imem_wdata | input | 15 | Instruction word to write |
| in_valid | input | 5 | Per input link: a word is presented this cycle |
| in_data | input | 5x32 | Per input link data |
| in_credit | output | 5 | Per input link: one buffer slot freed |
| out_valid | output | 5 | Per output link: word sent this cycle |
| out_data | output | 5x32 | Per output link data |
| out_credit | input | 5 | Per output link: neighbour freed one slot |

## Verification
The bench goes after the all-or-nothing rule by feeding only one of two sources of an instruction. A design that moved the ready half would show a word on one output and a credit pulse before the second source arrived. Multicast is checked by counting credit pulses: a switch that dequeued once per route would return three credits for one word. Credit starvation is driven until the output queue is full. A design that ignored the full queue would take a fifth word off its input and drop it, and a late word would go missing from the ordered list. The timing of idle instructions and of wrap to zero is checked to the exact cycle. A counter that skipped idle steps, or that wrapped one address late, would deliver the routed word an edge early or late.

// File: rtl/msw_pkg.sv
package msw_pkg;
  localparam int NPORT   = 5;
  localparam int SEL_W   = 3;
  localparam int INSTR_W = NPORT * SEL_W;

  localparam logic [SEL_W-1:0] SEL_NORTH = 3'd0;
  localparam logic [SEL_W-1:0] SEL_EAST  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_SOUTH = 3'd2;
  localparam logic [SEL_W-1:0] SEL_WEST  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_LOCAL = 3'd4;
  localparam logic [SEL_W-1:0] SEL_IDLE  = 3'd7;

  // a select names a real input only for codes below the port count
  function automatic logic sel_active(input logic [SEL_W-1:0] sel);
    return sel < SEL_W'(NPORT);
  endfunction

  // source select of output o inside an instruction word
  function automatic logic [SEL_W-1:0] sel_field(input logic [INSTR_W-1:0] instr,
                                                 input int o);
    return instr[o*SEL_W +: SEL_W];
  endfunction

  // true when the buffer picked by sel holds a word
  function automatic logic src_has_word(input logic [NPORT-1:0] empty,
                                        input logic [SEL_W-1:0] sel);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NPORT; i++)
      if (sel == SEL_W'(i)) r = !empty[i];
    return r;
  endfunction
endpackage

// File: rtl/msw_fifo.sv
module msw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign rdata = store[rd_q];

  always_ff @(posedge clk) begin
    if (push) store[wr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= ptr_step(wr_q);
      if (pop)  rd_q <= ptr_step(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R5
endmodule

// File: rtl/msw_out_port.sv
module msw_out_port #(
  parameter int W       = 32,
  parameter int DEPTH   = 2,
  parameter int CREDITS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  output logic         link_valid,
  output logic [W-1:0] link_data,
  input  logic         credit_ret
);
  localparam int CW = $clog2(CREDITS + 1);

  logic          q_empty;
  logic          send;
  logic [CW-1:0] credit_q;

  msw_fifo #(.W(W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push(push), .wdata(wdata),
    .pop(send), .rdata(link_data),
    .empty(q_empty), .full(full)
  );

  assign send       = !q_empty && (credit_q != '0);
  assign link_valid = send;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credit_q <= CW'(CREDITS);
    else        credit_q <= credit_q - CW'(send) + CW'(credit_ret);
  end

  AST_VALID_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |=> $past(credit_q) != '0); // R8
  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q <= CW'(CREDITS)); // R8
endmodule

// File: rtl/msw_sched.sv
module msw_sched
  import msw_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [AW-1:0]           cfg_last,
  input  logic                    imem_we,
  input  logic [AW-1:0]           imem_addr,
  input  logic [INSTR_W-1:0]      imem_wdata,
  input  logic [NPORT-1:0]        in_empty,
  input  logic [NPORT-1:0][W-1:0] in_head,
  input  logic [NPORT-1:0]        out_full,
  output logic [NPORT-1:0]        pop_in,
  output logic [NPORT-1:0]        push_out,
  output logic [NPORT-1:0][W-1:0] push_data,
  output logic                    fire
);
  logic [INSTR_W-1:0] imem [DEPTH];
  logic [AW-1:0]      pc_q;
  logic [INSTR_W-1:0] instr;
  logic [NPORT-1:0]   route_on;
  logic [NPORT-1:0]   route_ok;
  logic [NPORT-1:0]   src_used;

  function automatic logic [AW-1:0] pc_after(input logic [AW-1:0] pc,
                                             input logic [AW-1:0] last);
    return (pc == last) ? '0 : pc + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) imem[i] <= {NPORT{SEL_IDLE}};
    end else if (imem_we) begin
      imem[imem_addr] <= imem_wdata;
    end
  end

  assign instr = imem[pc_q];

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      route_on[o]  = sel_active(sel_field(instr, o));
      route_ok[o]  = !route_on[o] ||
                     (src_has_word(in_empty, sel_field(instr, o)) && !out_full[o]);
      push_data[o] = '0;
      for (int i = 0; i < NPORT; i++)
        if (sel_field(instr, o) == SEL_W'(i)) push_data[o] = in_head[i];
    end
  end

  always_comb begin
    src_used = '0;
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        if (route_on[o] && sel_field(instr, o) == SEL_W'(i)) src_used[i] = 1'b1;
  end

  assign fire     = run && (&route_ok);
  assign pop_in   = fire ? src_used : '0;
  assign push_out = fire ? route_on : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= '0;
    else if (fire) pc_q <= pc_after(pc_q, cfg_last);
  end

  AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pc_q)); // R5
  AST_PC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pc_q == cfg_last) |=> pc_q == '0); // R6
  AST_STOPPED_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pop_in == '0); // R7
endmodule

// File: rtl/static_route_switch.sv
module static_route_switch
  import msw_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int IMEM_DEPTH   = 16,
  parameter int IN_DEPTH     = 2,
  parameter int OUT_DEPTH    = 2,
  parameter int LINK_CREDITS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  input  logic [$clog2(IMEM_DEPTH)-1:0] cfg_last,
  input  logic                         imem_we,
  input  logic [$clog2(IMEM_DEPTH)-1:0] imem_addr,
  input  logic [INSTR_W-1:0]           imem_wdata,
  input  logic [NPORT-1:0]             in_valid,
  input  logic [NPORT-1:0][DATA_W-1:0] in_data,
  output logic [NPORT-1:0]             in_credit,
  output logic [NPORT-1:0]             out_valid,
  output logic [NPORT-1:0][DATA_W-1:0] out_data,
  input  logic [NPORT-1:0]             out_credit
);
  localparam int AW = $clog2(IMEM_DEPTH);

  logic [NPORT-1:0]             in_empty;
  logic [NPORT-1:0]             in_full;
  logic [NPORT-1:0][DATA_W-1:0] in_head;
  logic [NPORT-1:0]             out_full;
  logic [NPORT-1:0]             pop_in;
  logic [NPORT-1:0]             push_out;
  logic [NPORT-1:0][DATA_W-1:0] push_data;
  logic                         fire;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    msw_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_in (
      .clk(clk), .rst_n(rst_n),
      .push(in_valid[p]), .wdata(in_data[p]),
      .pop(pop_in[p]), .rdata(in_head[p]),
      .empty(in_empty[p]), .full(in_full[p])
    );

    msw_out_port #(.W(DATA_W), .DEPTH(OUT_DEPTH), .CREDITS(LINK_CREDITS)) u_out (
      .clk(clk), .rst_n(rst_n),
      .push(push_out[p]), .wdata(push_data[p]),
      .full(out_full[p]),
      .link_valid(out_valid[p]), .link_data(out_data[p]),
      .credit_ret(out_credit[p])
    );

    AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      out_full[p] |-> !push_out[p]); // R8
    AST_UPSTREAM_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
      in_full[p] |-> !in_valid[p]); // R9
  end

  msw_sched #(.W(DATA_W), .DEPTH(IMEM_DEPTH), .AW(AW)) u_sched (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_last(cfg_last),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .in_empty(in_empty), .in_head(in_head), .out_full(out_full),
    .pop_in(pop_in), .push_out(push_out), .push_data(push_data),
    .fire(fire)
  );

  assign in_credit = pop_in;

  AST_MOVE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_out != '0 || pop_in != '0) |-> fire); // R5
endmodule

// File: tb/sim_static_route_switch.sv
`timescale 1ns/1ps
module sim_static_route_switch;
  localparam int NP = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic [3:0]       cfg_last = '0;
  logic             imem_we = 1'b0;
  logic [3:0]       imem_addr = '0;
  logic [14:0]      imem_wdata = '0;
  logic [NP-1:0]    in_valid = '0;
  logic [NP-1:0][31:0] in_data = '0;
  logic [NP-1:0]    in_credit;
  logic [NP-1:0]    out_valid;
  logic [NP-1:0][31:0] out_data;
  logic [NP-1:0]    out_credit;
  logic [NP-1:0]    nb_credit = '0;
  logic [NP-1:0]    man_credit = '0;
  logic             auto_credit = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rx_cnt [NP];
  int cr_cnt [NP];
  logic [31:0] rx_log [NP][64];

  always #5 clk = ~clk;

  static_route_switch u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_last(cfg_last),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_credit(in_credit),
    .out_valid(out_valid), .out_data(out_data), .out_credit(out_credit)
  );

  assign out_credit = nb_credit | man_credit;

  // neighbour model and monitor, both at the falling edge
  initial for (int p = 0; p < NP; p++) begin rx_cnt[p] = 0; cr_cnt[p] = 0; end
  always @(negedge clk) begin
    nb_credit <= auto_credit ? out_valid : '0;
    if (rst_n) begin
      for (int p = 0; p < NP; p++) begin
        if (out_valid[p]) begin
          rx_log[p][rx_cnt[p] % 64] = out_data[p];
          rx_cnt[p] = rx_cnt[p] + 1;
        end
        if (in_credit[p]) cr_cnt[p] = cr_cnt[p] + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [14:0] mk(input logic [2:0] n, input logic [2:0] e,
                                     input logic [2:0] s, input logic [2:0] w,
                                     input logic [2:0] l);
    return {l, w, s, e, n};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 1'b0; in_valid = '0; auto_credit = 1'b0;
    man_credit = '0; cfg_last = '0;
    ticks(3);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic load(input int addr, input logic [14:0] w);
    imem_we = 1'b1; imem_addr = 4'(addr); imem_wdata = w;
    tick();
    imem_we = 1'b0;
  endtask

  task automatic send(input int p, input logic [31:0] d);
    in_valid[p] = 1'b1; in_data[p] = d;
    tick();
    in_valid[p] = 1'b0;
  endtask

  // vector: {src[2:0], dst[2:0], data[31:0]}
  localparam logic [37:0] VEC [6] = '{
    {3'd0, 3'd1, 32'hA000_0001},
    {3'd1, 3'd2, 32'hB000_0002},
    {3'd2, 3'd3, 32'hC000_0003},
    {3'd3, 3'd4, 32'hD000_0004},
    {3'd4, 3'd0, 32'hE000_0005},
    {3'd0, 3'd0, 32'hF0F0_0F0F}
  };

  initial begin
    int b0, b1, b2, bc;
    logic [14:0] w;

    // R1: reset state
    rst_n = 1'b0;
    ticks(2);
    check(out_valid == '0, "R1 out_valid in reset", 32'(out_valid), 0);
    check(in_credit == '0, "R1 in_credit in reset", 32'(in_credit), 0);
    rst_n = 1'b1;
    tick();
    check(out_valid == '0 && in_credit == '0, "R1 quiet after reset",
          32'({out_valid, in_credit}), 0);

    // table of single routes: R2 field position, R3 latency, R9 credit
    for (int v = 0; v < 6; v++) begin
      int src, dst;
      logic [31:0] d;
      src = int'(VEC[v][37:35]); dst = int'(VEC[v][34:32]); d = VEC[v][31:0];
      do_reset();
      w = '1;
      w[dst*3 +: 3] = 3'(src);
      load(0, w);
      auto_credit = 1'b1; run = 1'b1;
      tick();
      send(src, d);
      check(in_credit == 5'(1 << src), "R9 credit pulse on source",
            32'(in_credit), 32'(1 << src));
      check(out_valid == '0, "R3 nothing out after one edge", 32'(out_valid), 0);
      tick();
      check(out_valid == 5'(1 << dst), "R2 only selected output",
            32'(out_valid), 32'(1 << dst));
      check(out_data[dst] == d, "R3 data through switch", out_data[dst], d);
      tick();
      check(in_credit == '0, "R9 single credit pulse", 32'(in_credit), 0);
    end

    // R1: instruction store back to idle after reset
    do_reset();
    run = 1'b1;
    b0 = rx_cnt[0] + rx_cnt[1] + rx_cnt[2] + rx_cnt[3] + rx_cnt[4];
    send(0, 32'h1111_1111);
    ticks(4);
    check(rx_cnt[0] + rx_cnt[1] + rx_cnt[2] + rx_cnt[3] + rx_cnt[4] == b0,
          "R1 store idle after reset", 32'(rx_cnt[0] + rx_cnt[1]), 32'(b0));

    // R4: multicast north to east, south and local
    do_reset();
    load(0, mk(3'd7, 3'd0, 3'd0, 3'd7, 3'd0));
    auto_credit = 1'b1; run = 1'b1;
    bc = cr_cnt[0];
    send(0, 32'h5A5A_0004);
    tick();
    check(out_valid == 5'b10110, "R4 copied to three outputs", 32'(out_valid), 32'h16);
    check(out_data[1] == 32'h5A5A_0004 && out_data[2] == 32'h5A5A_0004 &&
          out_data[4] == 32'h5A5A_0004, "R4 copies carry the word",
          out_data[4], 32'h5A5A_0004);
    ticks(3);
    check(cr_cnt[0] == bc + 1, "R4 input consumed once", 32'(cr_cnt[0] - bc), 1);

    // R5: all or nothing
    do_reset();
    load(0, mk(3'd7, 3'd0, 3'd3, 3'd7, 3'd7));
    auto_credit = 1'b1; run = 1'b1;
    b1 = rx_cnt[1]; b2 = rx_cnt[2]; bc = cr_cnt[0];
    send(0, 32'h0000_00E1);
    ticks(4);
    check(rx_cnt[1] == b1 && rx_cnt[2] == b2, "R5 no partial route",
          32'(rx_cnt[1] - b1), 0);
    check(cr_cnt[0] == bc, "R5 ready source kept", 32'(cr_cnt[0] - bc), 0);
    send(3, 32'h0000_0053);
    tick();
    check(out_valid[1] && out_valid[2], "R5 both routes same cycle",
          32'(out_valid), 32'h06);
    check(out_data[1] == 32'h0000_00E1 && out_data[2] == 32'h0000_0053,
          "R5 route data", out_data[2], 32'h0000_0053);

    // R10 and R6: program order on east, then wrap
    do_reset();
    load(0, mk(3'd7, 3'd0, 3'd7, 3'd7, 3'd7));
    load(1, mk(3'd7, 3'd2, 3'd7, 3'd7, 3'd7));
    load(2, mk(3'd7, 3'd3, 3'd7, 3'd7, 3'd7));
    cfg_last = 4'd2;
    auto_credit = 1'b1; run = 1'b1;
    b1 = rx_cnt[1];
    send(3, 32'h0000_0333);
    send(2, 32'h0000_0222);
    send(0, 32'h0000_0111);
    ticks(8);
    check(rx_cnt[1] == b1 + 3, "R10 three words out", 32'(rx_cnt[1] - b1), 3);
    check(rx_log[1][b1 % 64] == 32'h111 && rx_log[1][(b1 + 1) % 64] == 32'h222 &&
          rx_log[1][(b1 + 2) % 64] == 32'h333, "R10 program order",
          rx_log[1][b1 % 64], 32'h111);
    send(0, 32'h0000_0444);
    ticks(3);
    check(rx_cnt[1] == b1 + 4 && rx_log[1][(b1 + 3) % 64] == 32'h444,
          "R6 wrap to address 0", rx_log[1][(b1 + 3) % 64], 32'h444);

    // R8: credit starvation and full queue
    do_reset();
    load(0, mk(3'd7, 3'd4, 3'd7, 3'd7, 3'd7));
    run = 1'b1;
    b1 = rx_cnt[1];
    for (int k = 1; k <= 4; k++) begin
      send(4, 32'(k));
      tick();
    end
    ticks(3);
    check(rx_cnt[1] == b1 + 2, "R8 sends stop at zero credit",
          32'(rx_cnt[1] - b1), 2);
    check(out_valid[1] == 1'b0, "R8 no valid without credit", 32'(out_valid), 0);
    bc = cr_cnt[4];
    send(4, 32'd5);
    ticks(4);
    check(cr_cnt[4] == bc, "R8 full queue blocks route", 32'(cr_cnt[4] - bc), 0);
    man_credit[1] = 1'b1;
    tick();
    man_credit[1] = 1'b0;
    auto_credit = 1'b1;
    ticks(10);
    check(rx_cnt[1] == b1 + 5, "R8 all words after credits", 32'(rx_cnt[1] - b1), 5);
    check(rx_log[1][(b1 + 2) % 64] == 32'd3 && rx_log[1][(b1 + 4) % 64] == 32'd5,
          "R10 order kept through stall", rx_log[1][(b1 + 4) % 64], 32'd5);

    // R7: run low
    do_reset();
    load(0, mk(3'd7, 3'd0, 3'd7, 3'd7, 3'd7));
    auto_credit = 1'b1;
    b1 = rx_cnt[1]; bc = cr_cnt[0];
    send(0, 32'h7777_0007);
    ticks(4);
    check(rx_cnt[1] == b1 && cr_cnt[0] == bc, "R7 stopped switch moves nothing",
          32'(rx_cnt[1] - b1), 0);
    run = 1'b1;
    tick();
    check(out_valid[1] && out_data[1] == 32'h7777_0007, "R7 moves once running",
          out_data[1], 32'h7777_0007);

    // R11 and R2: idle steps take one cycle each, idle codes 5 and 6
    do_reset();
    load(0, mk(3'd7, 3'd7, 3'd7, 3'd7, 3'd7));
    load(1, mk(3'd6, 3'd7, 3'd7, 3'd5, 3'd7));
    load(2, mk(3'd7, 3'd5, 3'd0, 3'd6, 3'd7));
    cfg_last = 4'd2;
    auto_credit = 1'b1;
    send(0, 32'h0000_0B11);
    b1 = rx_cnt[1]; b0 = rx_cnt[3];
    run = 1'b1;
    ticks(2);
    check(out_valid == '0, "R11 nothing after two idle steps", 32'(out_valid), 0);
    tick();
    check(out_valid == 5'b00100, "R11 routed word after idle steps",
          32'(out_valid), 32'h04);
    check(out_data[2] == 32'h0000_0B11, "R11 word value", out_data[2], 32'hB11);
    ticks(3);
    check(rx_cnt[1] == b1 && rx_cnt[3] == b0, "R2 codes 5 and 6 carry nothing",
          32'(rx_cnt[1] - b1), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule